// File: doc/BRIEF.md
# Asynchronous Serial Port with RS485 Driver Control

This block is the character engine of a serial port. A transmitter turns bytes into asynchronous frames on a single output line. A receiver recovers frames from an input line and reports each character with its error flags. Both halves run from a shared clock and from a one-cycle oversampling pulse, `tick16`, that an external baud generator supplies at sixteen times the bit rate. Every serial bit therefore lasts sixteen ticks.

Bytes enter on a valid/ready stream. The transmitter raises `tx_ready` only when it is idle, not sending a break, and, if flow control is on, the far end's clear-to-send is high. A byte is taken on a clock where `tx_valid` and `tx_ready` are both high. Received characters leave on a second valid/ready stream. A character stays on the outputs, unchanged, until the consumer takes it. A character that finishes while the previous one is still waiting is discarded. The consumer's `rx_ready` is also sent to the far end as request-to-send, so a stalled consumer throttles the sender.

The frame is one low start bit, 7 or 8 data bits sent least significant bit first, an optional parity bit, and 1 or 2 high stop bits. `drv_en` steers an RS485 transceiver and covers each frame exactly. A break request forces the line low, and the receiver recognises a break on its input.

Top module: `uart485_port`

## Requirements
- R1: With `cfg_len7`=1 a frame carries 7 data bits. Bit 7 of `tx_data` is not sent and does not enter the parity, and `rx_data[7]` is returned as 0. With `cfg_len7`=0 all 8 bits are carried.
- R2: `cfg_stop2`=0 sends one stop bit and `cfg_stop2`=1 sends two. Each stop bit is high and lasts 16 ticks.
- R3: `cfg_parity` selects the parity bit, which follows the data bits: 0 none (no bit), 1 odd (data plus parity has an odd count of ones), 2 even, 3 mark (always 1), 4 space (always 0).
- R4: `drv_en` is high from the clock that accepts a byte until the end of the 16th tick of the last stop bit, and whenever `brk_req` is high. While `drv_en` is low, `ser_out` is high.
- R5: While `brk_req` is high, `ser_out` is low and `tx_ready` is low, so no byte is accepted.
- R6: If the receiver samples low on the start bit, all data bits, the parity bit and all stop bits, it reports `rx_break`=1 with `rx_ferr`=1 and data 0. It then waits for the line to go high before it looks for a new start bit.
- R7: With `cfg_flow_en`=1, no byte is accepted while `cts_in` is low. A frame already started completes even if `cts_in` falls.
- R8: A start bit is accepted only after 8 consecutive low samples on ticks. A shorter low pulse produces no character. Each later bit is sampled 16 ticks after the previous sample.
- R9: `rts_out` equals `rx_ready` delayed by one clock, and it is 0 in reset.
- R10: `rx_ferr` is set when the first stop bit samples low. `rx_perr` is set when parity is enabled and the received parity bit differs from the one R3 computes from the received data.
- R11: `rx_valid` with `rx_data` and the flags stays stable until `rx_ready` is high. A character that completes while the output is still held is dropped.
- R12: The transmitter takes `tx_data` when `tx_valid` and `tx_ready` are both high. It then sends one low start bit of 16 ticks, followed by the data bits least significant bit first, each 16 ticks long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick16 | input | 1 | Oversampling pulse at 16x the bit rate |
| cfg_len7 | input | 1 | 1 selects 7 data bits, 0 selects 8 |
| cfg_stop2 | input | 1 | 1 selects two stop bits |
| cfg_parity | input | 3 | Parity mode, encoded as in R3 |
| cfg_flow_en | input | 1 | Enables clear-to-send gating of new frames |
| brk_req | input | 1 | Holds the line in break while high |
| tx_valid | input | 1 | Transmit byte offered |
| tx_ready | output | 1 | Transmitter can take a byte |
| tx_data | input | 8 | Transmit byte |
| ser_out | output | 1 | Serial line out, idle high |
| drv_en | output | 1 | RS485 driver enable |
| cts_in | input | 1 | Clear-to-send from the far end, high means go |
| rts_out | output | 1 | Request-to-send to the far end, high means send |
| ser_in | input | 1 | Serial line in, asynchronous |
| rx_valid | output | 1 | Received character available |
| rx_ready | input | 1 | Consumer takes the character |
| rx_data | output | 8 | Received character |
| rx_perr | output | 1 | Parity error for this character |
| rx_ferr | output | 1 | Framing error for this character |
| rx_break | output | 1 | Character is a break |

## Verification
A wrong transmit state or bit counter shows up on `ser_out` and `drv_en` within one tick period. The per-clock model follows every bit slot, so a bit that is one tick late, a missing parity bit or a missing second stop bit is reported at once. A receiver fault is seen when the character completes: a wrong sampling phase, bit count or flag gives a wrong `rx_data` or error flag about half a bit after the last stop edge. A stuck break state shows up as a repeated break or a missing character afterwards. Faults in the output hold, the dropping of characters, or the request-to-send path show up within a clock of the `rx_ready` change.

// File: rtl/uart485_pkg.sv
package uart485_pkg;

  typedef enum logic [2:0] {
    PAR_NONE  = 3'd0,
    PAR_ODD   = 3'd1,
    PAR_EVEN  = 3'd2,
    PAR_MARK  = 3'd3,
    PAR_SPACE = 3'd4
  } par_mode_t;

  typedef enum logic [2:0] {
    TX_IDLE, TX_START, TX_DATA, TX_PAR, TX_STOP
  } tx_state_t;

  typedef enum logic [2:0] {
    RX_IDLE, RX_HUNT, RX_DATA, RX_PAR, RX_STOP, RX_WAITHI
  } rx_state_t;

  // true when the mode inserts a parity bit
  function automatic logic par_on(input par_mode_t m);
    return (m == PAR_ODD) || (m == PAR_EVEN) || (m == PAR_MARK) || (m == PAR_SPACE);
  endfunction

  // parity bit value given the xor of the data bits
  function automatic logic par_from(input par_mode_t m, input logic x);
    case (m)
      PAR_ODD:  return ~x;
      PAR_EVEN: return x;
      PAR_MARK: return 1'b1;
      default:  return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/uart485_tx.sv
module uart485_tx
  import uart485_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              len7,
  input  logic              stop2,
  input  logic [2:0]        par_mode,
  input  logic              flow_en,
  input  logic              cts,
  input  logic              brk,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              line_out,
  output logic              drv_en
);
  localparam int CW = $clog2(OSR);
  localparam int BW = $clog2(DATA_W + 1);

  tx_state_t         st;
  logic [CW-1:0]     tcnt;
  logic [BW-1:0]     bidx, last_idx;
  logic [DATA_W-1:0] shreg, word_in;
  logic              par_q, stop_more, c_len7, c_stop2, bit_end, line_bit;
  par_mode_t         c_par;

  assign word_in  = len7 ? {1'b0, in_data[DATA_W-2:0]} : in_data;
  assign in_ready = (st == TX_IDLE) && !brk && (!flow_en || cts);
  assign bit_end  = tick && (tcnt == CW'(OSR - 1));
  assign last_idx = c_len7 ? BW'(DATA_W - 2) : BW'(DATA_W - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= TX_IDLE;
      tcnt      <= '0;
      bidx      <= '0;
      shreg     <= '0;
      par_q     <= 1'b0;
      stop_more <= 1'b0;
      c_len7    <= 1'b0;
      c_stop2   <= 1'b0;
      c_par     <= PAR_NONE;
    end else if (st == TX_IDLE) begin
      if (in_valid && in_ready) begin
        st      <= TX_START;
        tcnt    <= '0;
        shreg   <= word_in;
        par_q   <= par_from(par_mode_t'(par_mode), ^word_in);
        c_len7  <= len7;
        c_stop2 <= stop2;
        c_par   <= par_mode_t'(par_mode);
      end
    end else if (tick) begin
      tcnt <= bit_end ? '0 : tcnt + CW'(1);
      if (bit_end) begin
        case (st)
          TX_START: begin
            st   <= TX_DATA;
            bidx <= '0;
          end
          TX_DATA: begin
            shreg <= shreg >> 1;
            if (bidx == last_idx) begin
              if (par_on(c_par)) st <= TX_PAR;
              else begin
                st        <= TX_STOP;
                stop_more <= c_stop2;
              end
            end else begin
              bidx <= bidx + BW'(1);
            end
          end
          TX_PAR: begin
            st        <= TX_STOP;
            stop_more <= c_stop2;
          end
          TX_STOP: begin
            if (stop_more) stop_more <= 1'b0;
            else           st        <= TX_IDLE;
          end
          default: st <= TX_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    case (st)
      TX_START: line_bit = 1'b0;
      TX_DATA:  line_bit = shreg[0];
      TX_PAR:   line_bit = par_q;
      default:  line_bit = 1'b1;
    endcase
  end

  assign line_out = brk ? 1'b0 : line_bit;
  assign drv_en   = (st != TX_IDLE) || brk;

endmodule

// File: rtl/uart485_rx.sv
module uart485_rx
  import uart485_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 16,
  parameter int SYNC   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              len7,
  input  logic              stop2,
  input  logic [2:0]        par_mode,
  input  logic              line_in,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_perr,
  output logic              out_ferr,
  output logic              out_brk
);
  localparam int CW = $clog2(OSR);
  localparam int BW = $clog2(DATA_W + 1);

  logic [SYNC-1:0]   sync_q;
  logic              line;
  rx_state_t         st;
  logic [CW-1:0]     tcnt;
  logic [BW-1:0]     bidx, last_idx;
  logic [DATA_W-1:0] shreg, word;
  logic              par_bit, all_low, ferr_q, stop_more, stop_first;
  logic              c_len7, c_stop2, sample, fin, fe_now, pe_now, bk_now;
  par_mode_t         c_par;

  // input synchroniser, one flop per stage
  generate
    for (genvar s = 0; s < SYNC; s++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[s] <= 1'b1;
        else        sync_q[s] <= (s == 0) ? line_in : sync_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate
  assign line = sync_q[SYNC-1];

  assign last_idx = c_len7 ? BW'(DATA_W - 2) : BW'(DATA_W - 1);
  assign sample   = tick && (tcnt == CW'(OSR - 1)) &&
                    (st == RX_DATA || st == RX_PAR || st == RX_STOP);
  assign fin      = sample && (st == RX_STOP) && !stop_more;
  assign word     = c_len7 ? {1'b0, shreg[DATA_W-1:1]} : shreg;
  assign fe_now   = stop_first ? !line : ferr_q;
  assign pe_now   = par_on(c_par) && (par_bit != par_from(c_par, ^word));
  assign bk_now   = all_low && !line;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= RX_IDLE;
      tcnt       <= '0;
      bidx       <= '0;
      shreg      <= '0;
      par_bit    <= 1'b0;
      all_low    <= 1'b0;
      ferr_q     <= 1'b0;
      stop_more  <= 1'b0;
      stop_first <= 1'b0;
      c_len7     <= 1'b0;
      c_stop2    <= 1'b0;
      c_par      <= PAR_NONE;
    end else begin
      case (st)
        RX_IDLE: if (tick && !line) begin
          st      <= RX_HUNT;
          tcnt    <= CW'(1);
          c_len7  <= len7;
          c_stop2 <= stop2;
          c_par   <= par_mode_t'(par_mode);
        end
        RX_HUNT: if (tick) begin
          if (line) st <= RX_IDLE;
          else if (tcnt == CW'(OSR/2 - 1)) begin
            st      <= RX_DATA;
            tcnt    <= '0;
            bidx    <= '0;
            all_low <= 1'b1;
          end else tcnt <= tcnt + CW'(1);
        end
        RX_WAITHI: if (line) st <= RX_IDLE;
        default: if (tick) begin
          tcnt <= (tcnt == CW'(OSR - 1)) ? '0 : tcnt + CW'(1);
          if (sample) begin
            all_low <= all_low && !line;
            case (st)
              RX_DATA: begin
                shreg <= {line, shreg[DATA_W-1:1]};
                if (bidx == last_idx) begin
                  if (par_on(c_par)) st <= RX_PAR;
                  else begin
                    st         <= RX_STOP;
                    stop_more  <= c_stop2;
                    stop_first <= 1'b1;
                  end
                end else bidx <= bidx + BW'(1);
              end
              RX_PAR: begin
                par_bit    <= line;
                st         <= RX_STOP;
                stop_more  <= c_stop2;
                stop_first <= 1'b1;
              end
              default: begin
                if (stop_first) ferr_q <= !line;
                stop_first <= 1'b0;
                if (stop_more) stop_more <= 1'b0;
                else st <= fe_now ? RX_WAITHI : RX_IDLE;
              end
            endcase
          end
        end
      endcase
    end
  end

  // output register: hold until taken, drop a character that finds it full
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_perr  <= 1'b0;
      out_ferr  <= 1'b0;
      out_brk   <= 1'b0;
    end else begin
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (fin && (!out_valid || out_ready)) begin
        out_valid <= 1'b1;
        out_data  <= word;
        out_perr  <= pe_now;
        out_ferr  <= fe_now;
        out_brk   <= bk_now;
      end
    end
  end

endmodule

// File: rtl/uart485_port.sv
module uart485_port
  import uart485_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 16,
  parameter int SYNC   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick16,
  input  logic              cfg_len7,
  input  logic              cfg_stop2,
  input  logic [2:0]        cfg_parity,
  input  logic              cfg_flow_en,
  input  logic              brk_req,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [DATA_W-1:0] tx_data,
  output logic              ser_out,
  output logic              drv_en,
  input  logic              cts_in,
  output logic              rts_out,
  input  logic              ser_in,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_perr,
  output logic              rx_ferr,
  output logic              rx_break
);

  uart485_tx #(.DATA_W(DATA_W), .OSR(OSR)) u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick16),
    .len7(cfg_len7), .stop2(cfg_stop2), .par_mode(cfg_parity),
    .flow_en(cfg_flow_en), .cts(cts_in), .brk(brk_req),
    .in_valid(tx_valid), .in_ready(tx_ready), .in_data(tx_data),
    .line_out(ser_out), .drv_en(drv_en)
  );

  uart485_rx #(.DATA_W(DATA_W), .OSR(OSR), .SYNC(SYNC)) u_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick16),
    .len7(cfg_len7), .stop2(cfg_stop2), .par_mode(cfg_parity),
    .line_in(ser_in),
    .out_valid(rx_valid), .out_ready(rx_ready), .out_data(rx_data),
    .out_perr(rx_perr), .out_ferr(rx_ferr), .out_brk(rx_break)
  );

  // request-to-send mirrors the consumer's readiness one clock later
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rts_out <= 1'b0;
    else        rts_out <= rx_ready;
  end

endmodule

// File: rtl/uart485_chk.sv
module uart485_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_len7,
  input logic              cfg_flow_en,
  input logic              cts_in,
  input logic              brk_req,
  input logic              ser_out,
  input logic              drv_en,
  input logic              rts_out,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic [DATA_W-1:0] rx_data,
  input logic              rx_ferr,
  input logic              rx_break
);

  p_idle_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !drv_en |-> ser_out);

  p_break_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req |-> (!ser_out && drv_en));

  p_cts_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_flow_en && !cts_in && !drv_en && !brk_req) |=> (!drv_en || brk_req));

  p_rts_track_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (rts_out == $past(rx_ready)));

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

  p_len7_top_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && cfg_len7) |-> !rx_data[DATA_W-1]);

  p_break_ferr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_break) |-> rx_ferr);

endmodule

bind uart485_port uart485_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_len7(cfg_len7), .cfg_flow_en(cfg_flow_en),
  .cts_in(cts_in), .brk_req(brk_req), .ser_out(ser_out), .drv_en(drv_en),
  .rts_out(rts_out), .rx_valid(rx_valid), .rx_ready(rx_ready),
  .rx_data(rx_data), .rx_ferr(rx_ferr), .rx_break(rx_break)
);

// File: tb/sim_uart485_port.sv
module sim_uart485_port;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick16 = 1'b0;
  logic       cfg_len7 = 1'b0, cfg_stop2 = 1'b0, cfg_flow_en = 1'b0, brk_req = 1'b0;
  logic [2:0] cfg_parity = 3'd0;
  logic       tx_valid = 1'b0, cts_in = 1'b1, rx_ready = 1'b1;
  logic [7:0] tx_data = 8'h00;
  logic       tx_ready, ser_out, drv_en, rts_out, ser_in;
  logic       rx_valid, rx_perr, rx_ferr, rx_break;
  logic [7:0] rx_data;
  logic       loop = 1'b1, line_drv = 1'b1;

  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;  // 50 MHz

  assign ser_in = loop ? ser_out : line_drv;

  uart485_port u0 (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .cfg_len7(cfg_len7),
    .cfg_stop2(cfg_stop2), .cfg_parity(cfg_parity), .cfg_flow_en(cfg_flow_en),
    .brk_req(brk_req), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .ser_out(ser_out), .drv_en(drv_en), .cts_in(cts_in),
    .rts_out(rts_out), .ser_in(ser_in), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .rx_data(rx_data), .rx_perr(rx_perr),
    .rx_ferr(rx_ferr), .rx_break(rx_break)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // tick every fourth clock
  initial begin
    int ph = 0;
    forever begin
      @(negedge clk);
      tick16 = (ph == 3);
      ph = (ph + 1) % 4;
    end
  end

  // behavioural transmit and RTS model
  bit mq[$];
  int mcnt = 0;
  bit m_rts = 1'b0;

  function automatic bit model_par(input logic [2:0] m, input logic [7:0] w);
    case (m)
      3'd1: return ($countones(w) % 2) == 0;
      3'd2: return ($countones(w) % 2) == 1;
      3'd3: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mq.delete();
      mcnt = 0;
      m_rts = 1'b0;
    end else begin
      bit acc;
      acc = tx_valid && (mq.size() == 0) && !brk_req && (!cfg_flow_en || cts_in);
      if (tick16 && mq.size() > 0) begin
        mcnt++;
        if (mcnt == 16) begin
          mcnt = 0;
          void'(mq.pop_front());
        end
      end
      if (acc) begin
        logic [7:0] w;
        int nb;
        nb = cfg_len7 ? 7 : 8;
        w = cfg_len7 ? {1'b0, tx_data[6:0]} : tx_data;
        mq.push_back(1'b0);
        for (int i = 0; i < nb; i++) mq.push_back(w[i]);
        if (cfg_parity >= 3'd1 && cfg_parity <= 3'd4) mq.push_back(model_par(cfg_parity, w));
        mq.push_back(1'b1);
        if (cfg_stop2) mq.push_back(1'b1);
        mcnt = 0;
      end
      m_rts = rx_ready;
    end
  end

  // per-clock comparison, away from the edge
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (rst_n) begin
        bit e_ser, e_en, e_rdy;
        e_ser = brk_req ? 1'b0 : (mq.size() == 0 ? 1'b1 : mq[0]);
        e_en  = (mq.size() != 0) || brk_req;
        e_rdy = (mq.size() == 0) && !brk_req && (!cfg_flow_en || cts_in);
        check(ser_out == e_ser, "R1 R2 R3 R5 R12 ser_out", 32'(ser_out), 32'(e_ser));
        check(drv_en == e_en, "R4 drv_en", 32'(drv_en), 32'(e_en));
        check(tx_ready == e_rdy, "R5 R7 tx_ready", 32'(tx_ready), 32'(e_rdy));
        check(rts_out == m_rts, "R9 rts_out", 32'(rts_out), 32'(m_rts));
      end
    end
  end

  task automatic send_byte(input logic [7:0] d);
    @(negedge clk);
    tx_valid = 1'b1;
    tx_data  = d;
    #1;
    while (!tx_ready) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic expect_rx(input logic [7:0] d, input bit pe, input bit fe, input bit bk, input string tag);
    int n = 0;
    @(negedge clk);
    while (!rx_valid && n < 3000) begin
      @(negedge clk);
      n++;
    end
    check(rx_valid && rx_data == d && rx_perr == pe && rx_ferr == fe && rx_break == bk, tag,
          32'({rx_valid, rx_break, rx_ferr, rx_perr, rx_data}),
          32'({1'b1, bk, fe, pe, d}));
    @(negedge clk);
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (drv_en) @(negedge clk);
    repeat (8) @(negedge clk);
  endtask

  task automatic loop_byte(input logic [7:0] d, input logic [7:0] e, input string tag);
    fork
      send_byte(d);
      expect_rx(e, 1'b0, 1'b0, 1'b0, tag);
    join
    wait_idle();
  endtask

  task automatic drive_frame(input logic [15:0] bits, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      line_drv = bits[i];
      repeat (63) @(negedge clk);
    end
    @(negedge clk);
    line_drv = 1'b1;
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    check(ser_out == 1'b1 && drv_en == 1'b0 && rx_valid == 1'b0 && rts_out == 1'b0,
          "R4 R9 reset state", 32'({ser_out, drv_en, rx_valid, rts_out}), 32'(4'b1000));
    rst_n = 1'b1;
    repeat (10) @(negedge clk);

    // R12: 8N1 round trip
    loop_byte(8'hA5, 8'hA5, "R12 8N1 A5");
    // R1 R2: 7 bits, even parity, two stops, bit 7 dropped
    cfg_len7 = 1'b1; cfg_parity = 3'd2; cfg_stop2 = 1'b1;
    loop_byte(8'hD3, 8'h53, "R1 R2 7E2 D3");
    // R3: odd parity
    cfg_len7 = 1'b0; cfg_stop2 = 1'b0; cfg_parity = 3'd1;
    loop_byte(8'h7E, 8'h7E, "R3 8O1 7E");
    // R3: mark and space
    cfg_parity = 3'd3;
    loop_byte(8'h81, 8'h81, "R3 mark 81");
    cfg_parity = 3'd4;
    loop_byte(8'hFF, 8'hFF, "R3 space FF");
    // R1: 7 bits odd with only bit 7 set
    cfg_len7 = 1'b1; cfg_parity = 3'd1;
    loop_byte(8'h80, 8'h00, "R1 7O1 80");
    cfg_len7 = 1'b0; cfg_parity = 3'd0;

    // R7: flow control holds a new frame, not one in progress
    cfg_flow_en = 1'b1;
    cts_in = 1'b0;
    fork
      send_byte(8'h3C);
      expect_rx(8'h3C, 1'b0, 1'b0, 1'b0, "R7 frame after cts");
      begin
        repeat (300) @(negedge clk);
        check(drv_en == 1'b0, "R7 held while cts low", 32'(drv_en), 32'(0));
        cts_in = 1'b1;
        repeat (200) @(negedge clk);
        cts_in = 1'b0;
      end
    join
    wait_idle();
    cts_in = 1'b1;
    cfg_flow_en = 1'b0;

    // R5 R6: break with a pending byte
    fork
      begin
        @(negedge clk);
        brk_req = 1'b1;
        tx_valid = 1'b1;
        tx_data = 8'h99;
        repeat (960) @(negedge clk);
        check(tx_ready == 1'b0 && ser_out == 1'b0, "R5 break holds line",
              32'({tx_ready, ser_out}), 32'(0));
        tx_valid = 1'b0;
        brk_req = 1'b0;
      end
      expect_rx(8'h00, 1'b0, 1'b1, 1'b1, "R6 break detect");
    join
    repeat (200) @(negedge clk);
    check(rx_valid == 1'b0 && drv_en == 1'b0, "R5 R6 no frame or second break after release",
          32'({rx_valid, drv_en}), 32'(0));

    // R8: short low pulse rejected
    loop = 1'b0;
    @(negedge clk);
    line_drv = 1'b0;
    repeat (20) @(negedge clk);
    line_drv = 1'b1;
    begin
      int seen = 0;
      repeat (1000) begin
        @(negedge clk);
        if (rx_valid) seen++;
      end
      check(seen == 0, "R8 glitch ignored", 32'(seen), 32'(0));
    end

    // R10: parity error, even parity, data 01 with parity bit 0
    cfg_parity = 3'd2;
    fork
      drive_frame(16'h0402, 11);
      expect_rx(8'h01, 1'b1, 1'b0, 1'b0, "R10 parity error");
    join
    repeat (100) @(negedge clk);
    // R10: framing error, data 55 with low stop bit
    cfg_parity = 3'd0;
    fork
      drive_frame(16'h00AA, 10);
      expect_rx(8'h55, 1'b0, 1'b1, 1'b0, "R10 framing error");
    join
    repeat (100) @(negedge clk);
    loop = 1'b1;
    repeat (20) @(negedge clk);

    // R11 R9: back-pressure keeps the first character, drops the second
    rx_ready = 1'b0;
    repeat (3) @(negedge clk);
    check(rts_out == 1'b0, "R9 rts follows rx_ready", 32'(rts_out), 32'(0));
    send_byte(8'h11);
    wait_idle();
    send_byte(8'h22);
    wait_idle();
    repeat (50) @(negedge clk);
    check(rx_valid && rx_data == 8'h11, "R11 first character held",
          32'({rx_valid, rx_data}), 32'({1'b1, 8'h11}));
    rx_ready = 1'b1;
    @(negedge clk);
    repeat (200) @(negedge clk);
    check(rx_valid == 1'b0, "R11 second character dropped", 32'(rx_valid), 32'(0));
    check(rts_out == 1'b1, "R9 rts reasserted", 32'(rts_out), 32'(1));

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule